// File: doc/BRIEF.md
# Linked-List Hardware Queue Manager

This block keeps a small set of hardware packet queues whose descriptors are all chained through one shared linking memory. A producer appends a descriptor to a queue by presenting the descriptor's address together with a queue number on the push port. A consumer removes the oldest descriptor of a queue by presenting a queue number on the pop port. One cycle later the block returns that descriptor's address, or zero if the queue held nothing.

Descriptor addresses are not stored as data. Each accepted address is translated to a linking-memory index through a parameterised table of descriptor regions. Each region has a base address, a power-of-two descriptor size, a power-of-two descriptor count and the link index of its first descriptor. The linking entry of a descriptor holds the index of the descriptor queued behind it. Every queue keeps a head index, a tail index and an entry count. On a pop, the head index is translated back to an address. A combinational status port reports any queue's entry count without disturbing it.

The queue numbers served form one contiguous range, starting at `BASE_Q` and holding `NUM_Q` queues.

Top module: `qm_linked_queue`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `pop_valid` and `push_err` are 0 and every queue reports a count of 0.
- R2: A push with `push_en`=1, a valid address and an in-range queue number appends the address at that queue's tail and raises its count by one from the next cycle on. Addresses leave each queue in the order they entered it.
- R3: A pop with `pop_en`=1 makes `pop_valid` 1 in the next cycle. When the queue is non-empty, `pop_addr` carries its head address in that cycle and the count falls by one. `pop_valid` is 0 in any cycle that follows a cycle without `pop_en`, and `pop_addr` is then 0.
- R4: A pop from an empty queue gives `pop_valid`=1 and `pop_addr`=0 and leaves that queue's count at 0.
- R5: When a push and a pop name the same queue in one cycle, the push takes effect first. On an empty queue the pop returns the address just pushed and the count stays 0. On a queue holding one entry, the pop returns the old entry, the queue then holds only the new address, and the count stays 1.
- R6: A push address is valid if it lies in some region, between the region's base and base + count × size (base included, end excluded), and is a multiple of the size above the base. Its link index is the region's start index plus (address − base) / size. A popped address equals the pushed one. Defaults: region 0 has base 0x1000, size 64, 16 entries and start index 0. Region 1 has base 0x8000, size 128, 16 entries and start index 16.
- R7: A push whose address is invalid, or whose queue number is out of range, is dropped with no change to any queue. `push_err` is 1 in the following cycle only.
- R8: The queue numbers in range are `BASE_Q` to `BASE_Q`+`NUM_Q`−1 (defaults 8 to 11). A pop naming any other number returns `pop_addr`=0, and `peek_count` for any other number is 0.
- R9: `peek_count` shows the current count of the queue on `peek_q` in the same cycle, and changes no state.
- R10: Queues sharing the linking memory stay independent under interleaved pushes and pops across all queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_en | input | 1 | Push request this cycle |
| push_q | input | QNUM_W | Queue number for the push |
| push_addr | input | ADDR_W | Descriptor address to append |
| pop_en | input | 1 | Pop request this cycle |
| pop_q | input | QNUM_W | Queue number for the pop |
| pop_valid | output | 1 | Pop result present (one cycle after pop_en) |
| pop_addr | output | ADDR_W | Popped descriptor address, 0 if none |
| push_err | output | 1 | Previous push was rejected |
| peek_q | input | QNUM_W | Queue number to report |
| peek_count | output | CNT_W | Entry count of queue peek_q |

## Verification
The bench first uses directed sequences: a pop of an empty queue, a three-deep fill and drain, and same-cycle push plus pop on an empty queue and on a single-entry queue. These separate FIFO ordering from the bypass and head-forwarding paths. Addresses just below, just past and misaligned inside each region, as well as out-of-range queue numbers, show whether the translation bounds and the rejection path are right. A long run of random traffic follows. It interleaves pushes and pops over all queues, with stray queue numbers mixed in, and draws descriptors from both regions. This exercises shared-link corruption and count drift that the directed cases cannot reach. A behavioural model of the queues is compared against the outputs on every cycle.

// File: rtl/qm_pkg.sv
`timescale 1ns/1ps
package qm_pkg;

    // What one queue sees in a cycle
    typedef enum logic [1:0] {
        QOP_IDLE = 2'd0,
        QOP_PUSH = 2'd1,
        QOP_POP  = 2'd2,
        QOP_BOTH = 2'd3
    } qop_e;

    function automatic qop_e qop_decode(input logic push_here, input logic pop_here);
        qop_e op;
        case ({push_here, pop_here})
            2'b10:   op = QOP_PUSH;
            2'b01:   op = QOP_POP;
            2'b11:   op = QOP_BOTH;
            default: op = QOP_IDLE;
        endcase
        return op;
    endfunction

    // Default descriptor region layout
    localparam int          QM_DEF_REGS = 2;
    localparam int unsigned QM_DEF_BASE  [QM_DEF_REGS] = '{32'h0000_1000, 32'h0000_8000};
    localparam int          QM_DEF_SZLG  [QM_DEF_REGS] = '{6, 7};
    localparam int          QM_DEF_CNTLG [QM_DEF_REGS] = '{4, 4};
    localparam int          QM_DEF_START [QM_DEF_REGS] = '{0, 16};

endpackage

// File: rtl/qm_region_fwd.sv
`timescale 1ns/1ps
module qm_region_fwd #(
    parameter int          ADDR_W  = 32,
    parameter int          IDX_W   = 5,
    parameter int          NUM_REG = qm_pkg::QM_DEF_REGS,
    parameter int unsigned REG_BASE  [NUM_REG] = qm_pkg::QM_DEF_BASE,
    parameter int          REG_SZLG  [NUM_REG] = qm_pkg::QM_DEF_SZLG,
    parameter int          REG_CNTLG [NUM_REG] = qm_pkg::QM_DEF_CNTLG,
    parameter int          REG_START [NUM_REG] = qm_pkg::QM_DEF_START
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    logic [NUM_REG-1:0] hit_r;
    logic [IDX_W-1:0]   idx_r [NUM_REG];

    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(REG_BASE[r]);
        localparam logic [ADDR_W-1:0] MASK = (ADDR_W'(1) << REG_SZLG[r]) - ADDR_W'(1);
        logic [ADDR_W-1:0] off;
        assign off      = addr - BASE;
        assign hit_r[r] = (addr >= BASE)
                        && ((off >> (REG_SZLG[r] + REG_CNTLG[r])) == '0)
                        && ((off & MASK) == '0);
        assign idx_r[r] = IDX_W'(REG_START[r]) + IDX_W'(off >> REG_SZLG[r]);
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int r = NUM_REG - 1; r >= 0; r--) begin
            if (hit_r[r]) begin
                hit = 1'b1;
                idx = idx_r[r];
            end
        end
    end
endmodule

// File: rtl/qm_region_rev.sv
`timescale 1ns/1ps
module qm_region_rev #(
    parameter int          ADDR_W  = 32,
    parameter int          IDX_W   = 5,
    parameter int          NUM_REG = qm_pkg::QM_DEF_REGS,
    parameter int unsigned REG_BASE  [NUM_REG] = qm_pkg::QM_DEF_BASE,
    parameter int          REG_SZLG  [NUM_REG] = qm_pkg::QM_DEF_SZLG,
    parameter int          REG_CNTLG [NUM_REG] = qm_pkg::QM_DEF_CNTLG,
    parameter int          REG_START [NUM_REG] = qm_pkg::QM_DEF_START
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    logic [NUM_REG-1:0] in_r;
    logic [ADDR_W-1:0]  addr_r [NUM_REG];

    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        int rel;
        assign rel       = int'({1'b0, idx}) - REG_START[r];
        assign in_r[r]   = (rel >= 0) && (rel < (1 << REG_CNTLG[r]));
        assign addr_r[r] = ADDR_W'(REG_BASE[r]) + (ADDR_W'(rel) << REG_SZLG[r]);
    end

    always_comb begin
        addr = '0;
        for (int r = NUM_REG - 1; r >= 0; r--) begin
            if (in_r[r]) addr = addr_r[r];
        end
    end
endmodule

// File: rtl/qm_queue_store.sv
`timescale 1ns/1ps
module qm_queue_store
    import qm_pkg::*;
#(
    parameter int NUM_Q      = 4,
    parameter int LINK_DEPTH = 32,
    localparam int IDX_W = $clog2(LINK_DEPTH),
    localparam int CNT_W = $clog2(LINK_DEPTH + 1),
    localparam int QL_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_do,
    input  logic [QL_W-1:0]  push_ql,
    input  logic [IDX_W-1:0] push_idx,
    input  logic             pop_do,
    input  logic [QL_W-1:0]  pop_ql,
    input  logic [QL_W-1:0]  peek_ql,
    output logic             pop_got,
    output logic [IDX_W-1:0] pop_idx,
    output logic [CNT_W-1:0] peek_cnt
);
    logic [IDX_W-1:0] link_q [LINK_DEPTH];
    logic [IDX_W-1:0] head_a [NUM_Q];
    logic [IDX_W-1:0] tail_a [NUM_Q];
    logic [CNT_W-1:0] cnt_a  [NUM_Q];

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        logic [IDX_W-1:0] hd, tl;
        logic [CNT_W-1:0] ct;
        qop_e             op;

        assign op = qop_decode(push_do && (push_ql == QL_W'(g)),
                               pop_do  && (pop_ql  == QL_W'(g)));

        always_ff @(posedge clk) begin
            if (rst) begin
                hd <= '0;
                tl <= '0;
                ct <= '0;
            end else begin
                case (op)
                    QOP_PUSH: begin
                        if (ct == '0) hd <= push_idx;
                        tl <= push_idx;
                        ct <= ct + CNT_W'(1);
                    end
                    QOP_POP: begin
                        if (ct != '0) begin
                            hd <= link_q[hd];
                            ct <= ct - CNT_W'(1);
                        end
                    end
                    QOP_BOTH: begin
                        // push lands first; an empty queue just forwards it
                        if (ct != '0) begin
                            tl <= push_idx;
                            hd <= (ct == CNT_W'(1)) ? push_idx : link_q[hd];
                        end
                    end
                    default: ;
                endcase
            end
        end

        assign head_a[g] = hd;
        assign tail_a[g] = tl;
        assign cnt_a[g]  = ct;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINK_DEPTH; i++) link_q[i] <= '0;
        end else if (push_do && (cnt_a[push_ql] != '0)) begin
            link_q[tail_a[push_ql]] <= push_idx;
        end
    end

    logic pop_empty, same_q;
    assign pop_empty = (cnt_a[pop_ql] == '0);
    assign same_q    = push_do && pop_do && (push_ql == pop_ql);
    assign pop_got   = pop_do && (!pop_empty || same_q);
    assign pop_idx   = pop_empty ? push_idx : head_a[pop_ql];
    assign peek_cnt  = cnt_a[peek_ql];
endmodule

// File: rtl/qm_linked_queue.sv
`timescale 1ns/1ps
module qm_linked_queue #(
    parameter int          QNUM_W     = 8,
    parameter int          BASE_Q     = 8,
    parameter int          NUM_Q      = 4,
    parameter int          ADDR_W     = 32,
    parameter int          LINK_DEPTH = 32,
    parameter int          NUM_REG    = qm_pkg::QM_DEF_REGS,
    parameter int unsigned REG_BASE  [NUM_REG] = qm_pkg::QM_DEF_BASE,
    parameter int          REG_SZLG  [NUM_REG] = qm_pkg::QM_DEF_SZLG,
    parameter int          REG_CNTLG [NUM_REG] = qm_pkg::QM_DEF_CNTLG,
    parameter int          REG_START [NUM_REG] = qm_pkg::QM_DEF_START,
    localparam int IDX_W = $clog2(LINK_DEPTH),
    localparam int CNT_W = $clog2(LINK_DEPTH + 1),
    localparam int QL_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_en,
    input  logic [QNUM_W-1:0] push_q,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop_en,
    input  logic [QNUM_W-1:0] pop_q,
    output logic              pop_valid,
    output logic [ADDR_W-1:0] pop_addr,
    output logic              push_err,
    input  logic [QNUM_W-1:0] peek_q,
    output logic [CNT_W-1:0]  peek_count
);
    function automatic logic q_ok(input logic [QNUM_W-1:0] q);
        return (int'({1'b0, q}) >= BASE_Q) && (int'({1'b0, q}) < BASE_Q + NUM_Q);
    endfunction

    function automatic logic [QL_W-1:0] q_loc(input logic [QNUM_W-1:0] q);
        return QL_W'(int'({1'b0, q}) - BASE_Q);
    endfunction

    logic             push_hit, push_do, pop_do, pop_got;
    logic [IDX_W-1:0] push_idx, pop_idx;
    logic [CNT_W-1:0] peek_cnt;

    qm_region_fwd #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_REG(NUM_REG),
        .REG_BASE(REG_BASE), .REG_SZLG(REG_SZLG),
        .REG_CNTLG(REG_CNTLG), .REG_START(REG_START)
    ) u_fwd (
        .addr(push_addr),
        .hit (push_hit),
        .idx (push_idx)
    );

    assign push_do = push_en && push_hit && q_ok(push_q);
    assign pop_do  = pop_en && q_ok(pop_q);

    qm_queue_store #(
        .NUM_Q(NUM_Q), .LINK_DEPTH(LINK_DEPTH)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .push_do (push_do),
        .push_ql (q_loc(push_q)),
        .push_idx(push_idx),
        .pop_do  (pop_do),
        .pop_ql  (q_loc(pop_q)),
        .peek_ql (q_loc(peek_q)),
        .pop_got (pop_got),
        .pop_idx (pop_idx),
        .peek_cnt(peek_cnt)
    );

    logic             pop_got_r;
    logic [IDX_W-1:0] pop_idx_r;
    logic [ADDR_W-1:0] rev_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            pop_valid <= 1'b0;
            pop_got_r <= 1'b0;
            pop_idx_r <= '0;
            push_err  <= 1'b0;
        end else begin
            pop_valid <= pop_en;
            pop_got_r <= pop_got;
            pop_idx_r <= pop_idx;
            push_err  <= push_en && !push_do;
        end
    end

    qm_region_rev #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_REG(NUM_REG),
        .REG_BASE(REG_BASE), .REG_SZLG(REG_SZLG),
        .REG_CNTLG(REG_CNTLG), .REG_START(REG_START)
    ) u_rev (
        .idx (pop_idx_r),
        .addr(rev_addr)
    );

    assign pop_addr   = pop_got_r ? rev_addr : '0;
    assign peek_count = q_ok(peek_q) ? peek_cnt : '0;
endmodule

// File: rtl/qm_linked_queue_checker.sv
`timescale 1ns/1ps
module qm_linked_queue_checker #(
    parameter int QNUM_W     = 8,
    parameter int BASE_Q     = 8,
    parameter int NUM_Q      = 4,
    parameter int ADDR_W     = 32,
    parameter int LINK_DEPTH = 32,
    localparam int CNT_W = $clog2(LINK_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              push_en,
    input logic              pop_en,
    input logic [QNUM_W-1:0] pop_q,
    input logic              pop_valid,
    input logic [ADDR_W-1:0] pop_addr,
    input logic              push_err,
    input logic [CNT_W-1:0]  peek_count
);
    logic pop_q_ok;
    assign pop_q_ok = (int'({1'b0, pop_q}) >= BASE_Q) && (int'({1'b0, pop_q}) < BASE_Q + NUM_Q);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!pop_valid && !push_err));

    assert_pop_answered_R3: assert property (@(posedge clk) disable iff (rst)
        pop_en |=> pop_valid);

    assert_no_stray_pop_R3: assert property (@(posedge clk) disable iff (rst)
        !pop_en |=> !pop_valid);

    assert_idle_addr_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !pop_valid |-> (pop_addr == '0));

    assert_err_needs_push_R7: assert property (@(posedge clk) disable iff (rst)
        push_err |-> $past(push_en));

    assert_oob_pop_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !pop_q_ok) |=> (pop_addr == '0));

    assert_count_bounded_R9: assert property (@(posedge clk) disable iff (rst)
        int'(peek_count) <= LINK_DEPTH);
endmodule

bind qm_linked_queue qm_linked_queue_checker #(
    .QNUM_W(QNUM_W), .BASE_Q(BASE_Q), .NUM_Q(NUM_Q),
    .ADDR_W(ADDR_W), .LINK_DEPTH(LINK_DEPTH)
) u_chk (.*);

// File: tb/qm_linked_queue_bench.sv
`timescale 1ns/1ps
module qm_linked_queue_bench;
    localparam int QW = 8;
    localparam int BQ = 8;
    localparam int NQ = 4;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push_en = 1'b0;
    logic [QW-1:0] push_q = '0;
    logic [AW-1:0] push_addr = '0;
    logic          pop_en = 1'b0;
    logic [QW-1:0] pop_q = '0;
    logic          pop_valid;
    logic [AW-1:0] pop_addr;
    logic          push_err;
    logic [QW-1:0] peek_q = '0;
    logic [5:0]    peek_count;

    always #10 clk = ~clk;   // 50 MHz

    qm_linked_queue u_qm_linked_queue (
        .clk(clk), .rst(rst),
        .push_en(push_en), .push_q(push_q), .push_addr(push_addr),
        .pop_en(pop_en), .pop_q(pop_q),
        .pop_valid(pop_valid), .pop_addr(pop_addr), .push_err(push_err),
        .peek_q(peek_q), .peek_count(peek_count)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 0;
    int unsigned mq [NQ][$];
    int unsigned pool[$];

    function automatic bit addr_ok(input int unsigned a);
        return (a >= 32'h1000 && a < 32'h1400 && (a % 64) == 0) ||
               (a >= 32'h8000 && a < 32'h8800 && (a % 128) == 0);
    endfunction

    function automatic bit qn_ok(input int q);
        return q >= BQ && q < BQ + NQ;
    endfunction

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic sweep_peek();
        for (int q = BQ - 1; q <= BQ + NQ; q++) begin
            peek_q = QW'(q);
            #1;
            check("R9", $sformatf("peek count q%0d", q), peek_count,
                  qn_ok(q) ? mq[q - BQ].size() : 0);
        end
    endtask

    // One cycle of traffic, with the model updated push-first
    task automatic step(input bit pe, input int pq, input int unsigned pa,
                        input bit oe, input int oq, input string tag,
                        output int unsigned got);
        bit          exp_err;
        int unsigned exp_addr;
        @(negedge clk);
        push_en = pe; push_q = QW'(pq); push_addr = pa;
        pop_en  = oe; pop_q  = QW'(oq);
        exp_err = pe && !(addr_ok(pa) && qn_ok(pq));
        if (pe && !exp_err) mq[pq - BQ].push_back(pa);
        exp_addr = 0;
        if (oe && qn_ok(oq) && mq[oq - BQ].size() > 0) exp_addr = mq[oq - BQ].pop_front();
        got = exp_addr;
        @(posedge clk);
        #1;
        check(tag, "pop_valid", pop_valid, oe);
        check(tag, "pop_addr", pop_addr, exp_addr);
        check(pe ? tag : "R7", "push_err", push_err, exp_err);
        sweep_peek();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned g;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "pop_valid in reset", pop_valid, 0);
        check("R1", "push_err in reset", push_err, 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1", "pop_valid after reset", pop_valid, 0);
        check("R1", "push_err after reset", push_err, 0);
        sweep_peek();

        // R4: empty pop
        step(0, 0, 0, 1, 9, "R4", g);
        // R2/R3: fill and drain in order, mixing regions (R6)
        step(1, 8, 32'h1000, 0, 0, "R2", g);
        step(1, 8, 32'h83C0 + 32'h40, 0, 0, "R6", g);  // 0x8400
        step(1, 8, 32'h13C0, 0, 0, "R6", g);
        step(0, 0, 0, 1, 8, "R3", g);
        step(0, 0, 0, 1, 8, "R3", g);
        step(0, 0, 0, 1, 8, "R3", g);
        step(0, 0, 0, 1, 8, "R4", g);
        // R5: same queue both, empty then single-entry
        step(1, 10, 32'h1040, 1, 10, "R5", g);
        step(1, 10, 32'h1080, 0, 0, "R5", g);
        step(1, 10, 32'h8780, 1, 10, "R5", g);
        step(0, 0, 0, 1, 10, "R5", g);
        // R7: rejected addresses, R8: bad queue numbers
        step(1, 9, 32'h1001, 0, 0, "R7", g);
        step(1, 9, 32'h1400, 0, 0, "R7", g);
        step(1, 9, 32'h0FC0, 0, 0, "R7", g);
        step(1, 9, 32'h8800, 0, 0, "R7", g);
        step(1, 9, 32'h8040, 0, 0, "R7", g);
        step(1, 9, 0, 0, 0, "R7", g);
        step(1, 12, 32'h1100, 0, 0, "R8", g);
        step(1, 7, 32'h1100, 0, 0, "R8", g);
        step(1, 11, 32'h1100, 1, 12, "R8", g);
        step(0, 0, 0, 1, 11, "R6", g);

        // R10: random interleaved traffic over shared link memory
        for (int k = 0; k < 16; k++) begin
            pool.push_back(32'h1000 + k * 64);
            pool.push_back(32'h8000 + k * 128);
        end
        for (int k = 0; k < 3000; k++) begin
            bit          pe, oe;
            int          pq, oq, pick;
            int unsigned pa;
            pe = ($urandom % 100) < 55 && pool.size() > 0;
            oe = ($urandom % 100) < 45;
            pq = BQ - 1 + int'($urandom % (NQ + 2));
            oq = BQ - 1 + int'($urandom % (NQ + 2));
            pa = 0;
            pick = -1;
            if (pe) begin
                if (($urandom % 10) == 0) pa = 32'h1000 + ($urandom % 32'h8000);
                else begin
                    pick = int'($urandom % pool.size());
                    pa = pool[pick];
                end
            end
            if (pick >= 0 && addr_ok(pa) && qn_ok(pq)) pool.delete(pick);
            if (pick < 0 && pe && addr_ok(pa)) pa = pa + 1;  // keep stray valid addresses out
            step(pe, pq, pa, oe, oq, "R10", g);
            if (g != 0) pool.push_back(g);
        end

        @(negedge clk);
        push_en = 0; pop_en = 0;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule